// File: doc/BRIEF.md
# Looped Pattern Replay Feed for a Serializer

This block holds a precomputed one-bit density-modulated sequence that covers exactly one period of a periodic waveform, a sine for example. It plays that sequence back endlessly as parallel words to a downstream serializer. Nothing is computed in real time. The pattern is built off-chip and written word by word into on-chip memory. A length register then says how many words make up one period. The output frequency follows only from the serializer clock and the chosen length. Density modulation rather than pulse-width modulation keeps the serial line rich in transitions.

Loading happens while playback is stopped. Writes of pattern words and of the length are refused while the run input is high. When run is high, the block reads addresses 0 through N-1 and returns to 0 with no idle cycle. It presents one registered word on every cycle. The first word appears two clock edges after run is first sampled high. When run drops, the output goes to all-zero words and the next start begins again from address 0.

Top module: `loop_pattern_player`

## Requirements
- R1: While reset is held and after its release with run low, `word_valid` is 0 and `word_out` is all zeros.
- R2: A pattern write (`wr_en` high at a clock edge where `run` is low) stores `wr_data` at `wr_addr`, and that word is later replayed at the matching position in the period.
- R3: A pattern write presented while `run` is high is ignored, and the stored word at that address is unchanged on later playback.
- R4: While running with effective length N, the output words follow stored addresses 0,1,...,N-1,0,1,... with `word_valid` high on every cycle and no gap at the wrap.
- R5: If `run` is first sampled high at edge e, then `word_valid` is still 0 after e, and the word from address 0 is presented with `word_valid` high after edge e+1.
- R6: If `run` is sampled low at edge e, the output after e still carries the word already read. From edge e+1 on, `word_valid` is 0 and `word_out` is zero. The next start replays from address 0.
- R7: A length value of 0 is treated as 1, so the word at address 0 repeats on every cycle.
- R8: A length value above DEPTH is treated as DEPTH. A length of exactly DEPTH wraps from address DEPTH-1 to 0.
- R9: A length write (`len_wr_en` high) presented while `run` is high is ignored, and the period in force is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serializer word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Playback enable (level) |
| wr_en | input | 1 | Pattern word write strobe |
| wr_addr | input | ADDR_W | Pattern word address |
| wr_data | input | WORD_W | Pattern word, bit 0 first on the serial line |
| len_wr_en | input | 1 | Length register write strobe |
| len_value | input | LEN_W | Words per period (0 means 1, above DEPTH means DEPTH) |
| word_out | output | WORD_W | Parallel word to the serializer |
| word_valid | output | 1 | High while `word_out` carries pattern data |

## Verification
Playback is tried with several lengths, each with its own pattern content. A short odd period shows whether the wrap happens at the right word. A single-word period and a length of zero check the degenerate clamp. A length of exactly DEPTH checks the full-memory wrap, and an oversized length checks the upper clamp. Because every word differs, an off-by-one in the wrap or a duplicated word shows up as a mismatch. Directed cases then start and stop playback in mid-period to check the two-edge start latency, the drain word and the restart from address 0. They also attempt pattern and length writes during playback to confirm that later replay still shows the old content and period.

// File: rtl/lpp_pkg.sv
package lpp_pkg;

   // address bits needed to index a memory of the given depth
   function automatic int lpp_addr_bits(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

   // bits needed to hold a word count from 0 up to depth
   function automatic int lpp_len_bits(input int depth);
      return $clog2(depth + 1);
   endfunction

   // fixed latency from run sampled high to first valid word
   localparam int LPP_READ_LATENCY = 2;

endpackage

// File: rtl/lpp_pattern_ram.sv
module lpp_pattern_ram #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [WORD_W-1:0] wd,
   input  logic              re,
   input  logic [ADDR_W-1:0] ra,
   output logic [WORD_W-1:0] rq
);

   logic [WORD_W-1:0] store [DEPTH];

   // write port: one word per cycle
   always_ff @(posedge clk) begin
      if (we) begin
         store[wa] <= wd;
      end
   end

   // registered read port, first stage of the read latency
   always_ff @(posedge clk) begin
      if (re) begin
         rq <= store[ra];
      end
   end

endmodule

// File: rtl/lpp_addr_seq.sv
module lpp_addr_seq #(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 6,
   parameter int LEN_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              len_wr_en,
   input  logic [LEN_W-1:0]  len_value,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] last_addr
);

   localparam int LEN_MAX = (1 << LEN_W) - 1;

   logic [LEN_W-1:0]  len_sat;
   logic [ADDR_W-1:0] last_next;
   logic              len_take;

   // saturate oversize counts to the memory depth when the field can exceed it
   generate
      if (LEN_MAX > DEPTH) begin : g_clamp
         always_comb begin
            if (len_value > LEN_W'(DEPTH)) begin
               len_sat = LEN_W'(DEPTH);
            end else begin
               len_sat = len_value;
            end
         end
      end else begin : g_pass
         assign len_sat = len_value;
      end
   endgenerate

   // zero behaves as one word: last address 0
   always_comb begin
      if (len_sat == '0) begin
         last_next = '0;
      end else begin
         last_next = ADDR_W'(len_sat - LEN_W'(1));
      end
   end

   assign len_take = len_wr_en & ~run;

   // last address held precomputed so the wrap compare is a plain equality
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_addr <= ADDR_W'(DEPTH - 1);
      end else if (len_take) begin
         last_addr <= last_next;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_addr <= '0;
      end else if (!run) begin
         rd_addr <= '0;
      end else if (rd_addr == last_addr) begin
         rd_addr <= '0;
      end else begin
         rd_addr <= rd_addr + ADDR_W'(1);
      end
   end

endmodule

// File: rtl/lpp_out_stage.sv
module lpp_out_stage #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [WORD_W-1:0] rq,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid
);

   logic rd_live;

   // marks that the RAM register was loaded this cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_live <= 1'b0;
      end else begin
         rd_live <= run;
      end
   end

   // second latency stage: zero fill when idle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_out   <= '0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= rd_live;
         word_out   <= rd_live ? rq : '0;
      end
   end

endmodule

// File: rtl/loop_pattern_player.sv
module loop_pattern_player
   import lpp_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = lpp_addr_bits(DEPTH),
   localparam int LEN_W  = lpp_len_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              len_wr_en,
   input  logic [LEN_W-1:0]  len_value,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("loop_pattern_player: DEPTH must be at least 2");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("loop_pattern_player: WORD_W must be at least 1");
      end
      if (LPP_READ_LATENCY != 2) begin : g_bad_lat
         $error("loop_pattern_player: pipeline built for latency 2");
      end
   endgenerate

   logic [ADDR_W-1:0] rd_addr;
   logic [ADDR_W-1:0] seq_last;
   logic [WORD_W-1:0] ram_q;
   logic              wr_take;

   // pattern is frozen during playback
   assign wr_take = wr_en & ~run;

   lpp_addr_seq #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .len_wr_en(len_wr_en),
      .len_value(len_value),
      .rd_addr  (rd_addr),
      .last_addr(seq_last)
   );

   lpp_pattern_ram #(
      .WORD_W(WORD_W),
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W)
   ) u_ram (
      .clk(clk),
      .we (wr_take),
      .wa (wr_addr),
      .wd (wr_data),
      .re (run),
      .ra (rd_addr),
      .rq (ram_q)
   );

   lpp_out_stage #(
      .WORD_W(WORD_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .rq        (ram_q),
      .word_out  (word_out),
      .word_valid(word_valid)
   );

endmodule

// File: rtl/lpp_checker.sv
module lpp_checker #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [ADDR_W-1:0] last_addr,
   input logic [WORD_W-1:0] word_out,
   input logic              word_valid
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!word_valid && word_out == '0));

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> word_out == '0);

   // R5
   start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ##2 word_valid);

   // R6
   stop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> ##2 !word_valid);

   // R6
   stop_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> rd_addr == '0);

   // R4
   addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr <= last_addr);

   // R4
   wrap_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rd_addr == last_addr) |=> rd_addr == '0);

   // R9
   len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(last_addr));

endmodule

bind loop_pattern_player lpp_checker #(
   .WORD_W(WORD_W),
   .ADDR_W(ADDR_W)
) u_lpp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .rd_addr   (rd_addr),
   .last_addr (seq_last),
   .word_out  (word_out),
   .word_valid(word_valid)
);

// File: tb/loop_pattern_player_bench.sv
`timescale 1ns/1ps
module loop_pattern_player_bench;

   localparam int WORD_W = 16;
   localparam int DEPTH  = 64;
   localparam int ADDR_W = 6;
   localparam int LEN_W  = 7;

   typedef struct packed {
      logic [7:0] len;
      logic [7:0] cycles;
      logic [7:0] seed;
   } vec_t;

   // len, cycles observed, pattern seed
   localparam vec_t VECS [6] = '{
      '{8'd5,   8'd12, 8'd1},   // R4 short odd period, stop mid-period
      '{8'd1,   8'd4,  8'd2},   // R4 single word period
      '{8'd0,   8'd5,  8'd3},   // R7 zero treated as one
      '{8'd64,  8'd70, 8'd4},   // R8 full depth wrap
      '{8'd100, 8'd70, 8'd5},   // R8 oversize clamped to DEPTH
      '{8'd7,   8'd20, 8'd6}    // R2 R4 another period
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              run = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [WORD_W-1:0] wr_data = '0;
   logic              len_wr_en = 1'b0;
   logic [LEN_W-1:0]  len_value = '0;
   logic [WORD_W-1:0] word_out;
   logic              word_valid;

   logic [WORD_W-1:0] exp_mem [DEPTH];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   loop_pattern_player #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_loop_pattern_player (
      .clk(clk), .rst_n(rst_n), .run(run),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .len_wr_en(len_wr_en), .len_value(len_value),
      .word_out(word_out), .word_valid(word_valid)
   );

   function automatic logic [WORD_W-1:0] pat(input int s, input int i);
      return WORD_W'((s * 945 + i * 40503 + 17) ^ (i << 5) ^ (s << 11));
   endfunction

   function automatic int eff_len(input int n);
      if (n == 0) return 1;
      if (n > DEPTH) return DEPTH;
      return n;
   endfunction

   task automatic chk(input string req, input logic [WORD_W-1:0] act,
                      input logic [WORD_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_pattern(input int seed);
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_addr = ADDR_W'(i);
         wr_data = pat(seed, i);
         exp_mem[i] = pat(seed, i);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_len(input int n);
      @(negedge clk);
      len_wr_en = 1'b1;
      len_value = LEN_W'(n);
      @(negedge clk);
      len_wr_en = 1'b0;
   endtask

   // start, check every word for cycles, stop, check drain and idle
   task automatic play_and_check(input int effn, input int cycles, input string req);
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      chk("R5 valid still low after first edge", WORD_W'(word_valid), '0);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         chk("R4 valid", WORD_W'(word_valid), WORD_W'(1));
         chk(req, word_out, exp_mem[k % effn]);
      end
      run = 1'b0;
      @(negedge clk);
      chk("R6 drain word", word_out, exp_mem[cycles % effn]);
      @(negedge clk);
      chk("R6 idle valid", WORD_W'(word_valid), '0);
      chk("R6 idle zero", word_out, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset valid", WORD_W'(word_valid), '0);
      chk("R1 reset word", word_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 post-reset word", word_out, '0);

      for (int v = 0; v < 6; v++) begin
         load_pattern(int'(VECS[v].seed));
         set_len(int'(VECS[v].len));
         play_and_check(eff_len(int'(VECS[v].len)), int'(VECS[v].cycles),
                        "R2 R4 R7 R8 replay word");
      end

      // R6 restart from address 0 after a mid-period stop
      load_pattern(9);
      set_len(6);
      play_and_check(6, 4, "R6 first run");
      play_and_check(6, 9, "R6 restart from zero");

      // R3 write attempt during playback
      @(negedge clk);
      run = 1'b1;
      wr_en = 1'b1;
      wr_addr = '0;
      wr_data = ~exp_mem[0];
      repeat (3) @(negedge clk);
      wr_en = 1'b0;
      // R9 length write attempt during playback
      len_wr_en = 1'b1;
      len_value = LEN_W'(2);
      @(negedge clk);
      len_wr_en = 1'b0;
      run = 1'b0;
      repeat (3) @(negedge clk);
      play_and_check(6, 13, "R3 R9 content and period kept");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule